// File: doc/BRIEF.md
# Selectable Output Word Formatter

This block takes one full-precision 38-bit two's complement sample (an in-phase or a quadrature result of a lowpass chain) and turns it into the output representation chosen by three select inputs. The same logic serves both channels, so a channel gets its format from the selects and not from a separate path.

In fixed-point mode the block keeps the most significant 16, 24, 32 or 38 bits of the sample and drops the low bits. It then writes that truncated word as two's complement, signed magnitude or offset binary. In floating-point mode it ignores the width and encoding selects. It reads the whole 38-bit sample as a signed integer and produces an IEEE-754 single-precision word. A leading-one detector and a normalising shifter do this, and the mantissa is truncated toward zero. The result is registered: each accepted sample appears one clock later together with a valid strobe, and the output word holds its value between strobes.

Top module: `outfmt_core`

## Requirements
- R1: While reset is asserted and at the first edge after it, `out_vld` is 0 and `out_word` is all zeros.
- R2: A sample presented with `in_vld`=1 at a rising edge appears on `out_word`, with `out_vld`=1, after exactly one clock. `out_vld` is 0 after a clock edge at which `in_vld` was 0, and `out_word` then keeps its previous value whatever the other inputs do.
- R3: With `float_en`=0, `width_sel` codes 0, 1, 2 and 3 select N = 16, 24, 32 and 38. The formatter keeps input bits [37:38-N], places the result in `out_word[N-1:0]`, and drives the bits above N-1 to 0.
- R4: `code_sel`=0 gives the truncated word in two's complement. The spare code 3 behaves exactly like code 0.
- R5: `code_sel`=1 gives signed magnitude. Bit N-1 is the sign, and bits N-2..0 hold the magnitude of the truncated value. A non-negative value comes out unchanged.
- R6: In signed magnitude, a truncated value equal to -2^(N-1) saturates to an all-ones word: sign set and the largest magnitude.
- R7: `code_sel`=2 gives offset binary. This is the truncated two's complement word with bit N-1 inverted.
- R8: With `float_en`=1 the widths and codes are ignored and `out_word[31:0]` is a single-precision float of the input read as a signed integer. Bit 31 is the sign, bits 30:23 hold (leading-one position + 127), bits 22:0 hold the fraction, and bits 37:32 are 0.
- R9: The float fraction is the magnitude's bits below the leading one, truncated toward zero, not rounded.
- R10: A zero input in float mode gives an all-zero output word.
- R11: A negative input in float mode uses the magnitude of its two's complement value. This includes -2^37, which gives exponent 164 and a zero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Sample strobe |
| in_data | input | 38 | Full-precision two's complement sample |
| width_sel | input | 2 | Fixed-point width: 0=16, 1=24, 2=32, 3=38 |
| code_sel | input | 2 | Fixed-point code: 0=two's complement, 1=signed magnitude, 2=offset binary, 3=as 0 |
| float_en | input | 1 | 1 selects single-precision float output |
| out_vld | output | 1 | Output strobe, one clock after `in_vld` |
| out_word | output | 38 | Formatted word, right-aligned, upper bits zero |

## Verification
The hardest cases to reach from the ports are the saturation corner of signed magnitude and the extremes of the normaliser. Saturation needs the kept top bits to be exactly -2^(N-1) while the dropped low bits hold something else. The normaliser extremes are a leading one at position 0 and at position 37, plus the most negative sample, whose magnitude does not fit in a signed field. The stimulus builds these cases directly for every width. It fills the discarded low bits with nonzero patterns and applies single-bit and all-ones magnitudes in float mode. It then adds a long stretch of random samples, formats and widths, sent back to back and with idle gaps, so that the hold behaviour is exercised too.

// File: rtl/outfmt_pkg.sv
// Package: shared constants, select codes and the width table for the
// output word formatter. Assumes a 38-bit source sample.
package outfmt_pkg;

    localparam int DATA_W   = 38;
    localparam int NUM_WSEL = 4;
    localparam int MANT_W   = 23;
    localparam int EXP_W    = 8;
    localparam int EXP_BIAS = 127;
    localparam int FLT_W    = 1 + EXP_W + MANT_W;

    typedef enum logic [1:0] {
        FMT_TWOS = 2'd0,
        FMT_SMAG = 2'd1,
        FMT_OFFS = 2'd2,
        FMT_SPARE = 2'd3
    } fx_code_e;

    // Width in bits selected by a width_sel code.
    function automatic int fx_width(input int idx);
        case (idx)
            0:       return 16;
            1:       return 24;
            2:       return 32;
            default: return 38;
        endcase
    endfunction

endpackage

// File: rtl/outfmt_lzd.sv
// Leading-one detector: reports the index of the highest set bit of a
// vector and whether any bit is set. Purely combinational.
module outfmt_lzd #(
    parameter int W     = 38,
    localparam int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos,
    output logic             any
);

    // Scan upward so the highest set bit wins.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = POS_W'(i);
        end
    end

    // Flag a non-zero vector.
    assign any = |vec;

endmodule

// File: rtl/outfmt_fixed.sv
// Fixed-point path: builds, for each selectable width, the truncated
// word in the requested code, then picks one by width_sel. Results are
// right-aligned in a DATA_W word with zero upper bits. Combinational.
module outfmt_fixed
    import outfmt_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        width_sel,
    input  logic [1:0]        code_sel,
    output logic [DATA_W-1:0] fx_word
);

    logic [DATA_W-1:0] cand [NUM_WSEL];
    fx_code_e          code;

    assign code = fx_code_e'(code_sel);

    for (genvar g = 0; g < NUM_WSEL; g++) begin : g_width
        localparam int W = fx_width(g);
        logic [W-1:0] trunc;
        logic [W-1:0] smag;
        logic [W-1:0] offs;
        logic [W-1:0] sel;

        // Keep the top W bits of the sample.
        assign trunc = din[DATA_W-1 -: W];

        // Signed magnitude, saturating the most negative value.
        always_comb begin
            if (!trunc[W-1]) begin
                smag = trunc;
            end else if (trunc[W-2:0] == '0) begin
                smag = '1;
            end else begin
                smag = {1'b1, (W-1)'(~trunc[W-2:0] + 1'b1)};
            end
        end

        // Offset binary by flipping the sign bit.
        assign offs = {~trunc[W-1], trunc[W-2:0]};

        // Choose the code for this width.
        always_comb begin
            case (code)
                FMT_SMAG: sel = smag;
                FMT_OFFS: sel = offs;
                default:  sel = trunc;
            endcase
        end

        assign cand[g] = DATA_W'(sel);
    end

    // Select the width.
    assign fx_word = cand[width_sel];

endmodule

// File: rtl/outfmt_float.sv
// Float path: reads the sample as a signed integer and forms an IEEE-754
// single-precision word. Fraction truncated toward zero; zero in gives
// zero out. Combinational.
module outfmt_float
    import outfmt_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    output logic [FLT_W-1:0]  flt_word
);

    localparam int POS_W = $clog2(DATA_W);

    logic              sgn;
    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] norm;
    logic [POS_W-1:0]  lead;
    logic              nz;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] frac;

    // Magnitude of the two's complement sample (fits unsigned).
    assign sgn = din[DATA_W-1];
    assign mag = sgn ? (~din + 1'b1) : din;

    outfmt_lzd #(.W(DATA_W)) u_lzd (
        .vec (mag),
        .pos (lead),
        .any (nz)
    );

    // Shift the leading one to the top bit.
    assign norm = mag << (POS_W'(DATA_W - 1) - lead);

    // Exponent and truncated fraction.
    assign expo = EXP_W'(lead) + EXP_W'(EXP_BIAS);
    assign frac = norm[DATA_W-2 -: MANT_W];

    // Assemble, forcing zero for a zero sample.
    assign flt_word = nz ? {sgn, expo, frac} : '0;

    // Normaliser must leave a one at the top for any non-zero input.
    always_comb begin
        if (nz) begin
            a_r8_norm_lead : assert (norm[DATA_W-1]);
        end
    end

endmodule

// File: rtl/outfmt_core.sv
// Top of the output word formatter: chooses the fixed or float path and
// registers the word and strobe with one cycle of latency. The word holds
// between strobes. Synchronous active-low reset.
module outfmt_core
    import outfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [37:0]       in_data,
    input  logic [1:0]        width_sel,
    input  logic [1:0]        code_sel,
    input  logic              float_en,
    output logic              out_vld,
    output logic [37:0]       out_word
);

    logic [DATA_W-1:0] fx_word;
    logic [FLT_W-1:0]  flt_word;
    logic [DATA_W-1:0] nxt_word;

    outfmt_fixed u_fixed (
        .din       (in_data),
        .width_sel (width_sel),
        .code_sel  (code_sel),
        .fx_word   (fx_word)
    );

    outfmt_float u_float (
        .din      (in_data),
        .flt_word (flt_word)
    );

    // Pick the path.
    assign nxt_word = float_en ? DATA_W'(flt_word) : fx_word;

    // Output register: load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_word <= nxt_word;
        end
    end

    // Arms the temporal checks one cycle after reset release.
    logic chk_armed;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    a_r2_vld_follows : assert property (@(posedge clk) disable iff (!rst_n)
        chk_armed |-> (out_vld == $past(in_vld)));

    a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && !$past(in_vld)) |-> $stable(out_word));

    a_r3_upper_clear : assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(in_vld && !float_en && width_sel == 2'd0))
        |-> (out_word[DATA_W-1:fx_width(0)] == '0));

    a_r8_float_upper : assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(in_vld && float_en))
        |-> (out_word[DATA_W-1:FLT_W] == '0));

    a_r10_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(in_vld && float_en && in_data == '0))
        |-> (out_word == '0));

endmodule

// File: tb/outfmt_core_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes model results, the monitor pops and
// compares them as out_vld appears.
module outfmt_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [37:0] in_data = '0;
    logic [1:0]  width_sel = '0;
    logic [1:0]  code_sel = '0;
    logic        float_en = 1'b0;
    logic        out_vld;
    logic [37:0] out_word;

    int checks = 0;
    int fails  = 0;
    logic [37:0] exp_q [$];
    string       tag_q [$];
    logic [37:0] last_word = '0;
    logic        mon_on = 1'b0;

    always #10 clk = ~clk;

    outfmt_core u_outfmt_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_data   (in_data),
        .width_sel (width_sel),
        .code_sel  (code_sel),
        .float_en  (float_en),
        .out_vld   (out_vld),
        .out_word  (out_word)
    );

    function automatic int wid(input logic [1:0] ws);
        case (ws)
            2'd0: return 16;
            2'd1: return 24;
            2'd2: return 32;
            default: return 38;
        endcase
    endfunction

    // Independent reference model.
    function automatic logic [37:0] model(input logic [37:0] d, input logic [1:0] ws,
                                          input logic [1:0] cs, input logic fp);
        longint v, t, m, r;
        int     n, p;
        longint mant;
        v = {{26{d[37]}}, d};
        if (fp) begin
            if (v == 0) return '0;
            m = (v < 0) ? -v : v;
            p = 0;
            for (int i = 0; i < 38; i++) if (m[i]) p = i;
            if (p >= 23) mant = (m >> (p - 23)) & 64'h7FFFFF;
            else         mant = (m << (23 - p)) & 64'h7FFFFF;
            r = ((v < 0) ? (64'd1 << 31) : 64'd0) | (longint'(p + 127) << 23) | mant;
            return r[37:0];
        end
        n = wid(ws);
        t = v >>> (38 - n);
        r = t & ((64'd1 << n) - 1);
        if (cs == 2'd2) r = r ^ (64'd1 << (n - 1));
        else if (cs == 2'd1 && t < 0) begin
            m = -t;
            if (m > (64'd1 << (n - 1)) - 1) m = (64'd1 << (n - 1)) - 1;
            r = (64'd1 << (n - 1)) | m;
        end
        return r[37:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [37:0] act, input logic [37:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // Driver: one strobed sample, expectation queued.
    task automatic drive(input logic [37:0] d, input logic [1:0] ws, input logic [1:0] cs,
                         input logic fp, input string req);
        @(negedge clk);
        in_vld = 1'b1; in_data = d; width_sel = ws; code_sel = cs; float_en = fp;
        exp_q.push_back(model(d, ws, cs, fp));
        tag_q.push_back(req);
    endtask

    // Idle cycles with changing inputs (R2 hold).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0; in_data = {$urandom, $urandom} ;
            width_sel = 2'($urandom); code_sel = 2'($urandom); float_en = 1'($urandom);
        end
    endtask

    // Monitor: compare on strobe, check hold otherwise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected strobe", out_word, 'x);
                end else begin
                    logic [37:0] e;
                    string tg;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(out_word === e, tg, out_word, e);
                end
            end else begin
                check(out_word === last_word, "R2 hold", out_word, last_word);
            end
            last_word = out_word;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_vld === 1'b0, "R1 vld in reset", {37'd0, out_vld}, '0);
        check(out_word === '0, "R1 word in reset", out_word, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld === 1'b0 && out_word === '0, "R1 after reset", out_word, '0);
        mon_on = 1'b1;

        // R3 / R4 widths, two's complement and spare code.
        for (int w = 0; w < 4; w++) begin
            drive(38'h12_3456_789A, 2'(w), 2'd0, 1'b0, "R3 R4 twos positive");
            drive(38'h3A_BCDE_F012, 2'(w), 2'd3, 1'b0, "R4 spare code");
            drive(38'h3F_FFFF_FFFF, 2'(w), 2'd0, 1'b0, "R3 minus one");
        end
        idle(3);
        // R5 / R6 signed magnitude.
        for (int w = 0; w < 4; w++) begin
            drive(38'h0C_0000_1111, 2'(w), 2'd1, 1'b0, "R5 smag positive");
            drive(38'h3F_FFFF_FFFF, 2'(w), 2'd1, 1'b0, "R5 smag minus one");
            drive(38'h2A_5A5A_5A5A, 2'(w), 2'd1, 1'b0, "R5 smag negative");
            drive(38'h20_0000_0000 | ((38'd1 << (38 - wid(2'(w)))) - 1) & 38'h0F_FFFF_FFFF,
                  2'(w), 2'd1, 1'b0, "R6 smag saturation");
        end
        drive(38'h20_0000_0000, 2'd3, 2'd1, 1'b0, "R6 smag full-width min");
        idle(2);
        // R7 offset binary.
        for (int w = 0; w < 4; w++) begin
            drive(38'h20_0000_0000, 2'(w), 2'd2, 1'b0, "R7 offset min");
            drive(38'h1F_FFFF_FFFF, 2'(w), 2'd2, 1'b0, "R7 offset max");
            drive(38'h00_0000_0000, 2'(w), 2'd2, 1'b0, "R7 offset zero");
        end
        idle(2);
        // R8 - R11 float.
        drive(38'd1, 2'd0, 2'd1, 1'b1, "R8 float one");
        drive(38'd3, 2'd2, 2'd2, 1'b1, "R8 float three");
        drive(38'h1F_FFFF_FFFF, 2'd1, 2'd0, 1'b1, "R9 float truncation");
        drive(38'h00_0123_4567, 2'd3, 2'd1, 1'b1, "R9 float mid");
        drive(38'd0, 2'd1, 2'd2, 1'b1, "R10 float zero");
        drive(38'h3F_FFFF_FFFF, 2'd0, 2'd0, 1'b1, "R11 float minus one");
        drive(38'h20_0000_0000, 2'd0, 2'd0, 1'b1, "R11 float most negative");
        drive(38'h30_0000_0001, 2'd0, 2'd0, 1'b1, "R11 float negative");
        idle(2);
        // Random mix.
        for (int i = 0; i < 400; i++) begin
            drive({$urandom, $urandom} >> ($urandom % 38), 2'($urandom), 2'($urandom),
                  1'($urandom), "R2 R3 R8 random");
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(3);
        check(exp_q.size() == 0, "R2 all results seen", 38'(exp_q.size()), '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule